// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer N and emits one pulse per division cycle, for the feedback input of a phase detector. It is not a single wide counter. Inside, a divide-by-16/17 prescaler runs at the input rate, and two slower counters decide which modulus the prescaler uses. The swallow counter keeps the prescaler at divide-by-17 for its first A prescaler cycles. The program counter ends the division cycle after B prescaler cycles in total. One output period therefore lasts 17·A + 16·(B − A) = 16·B + A input clocks.

The user supplies N as one 17-bit word and never handles A or B directly. The four low bits of N become the swallow count A and the upper thirteen bits become the program count B. A new N is checked and captured only when a division cycle ends, so every period runs on one consistent setting. An illegal N raises an error flag and is ignored. The divider keeps running on the last legal setting.

Top module: `psw_fb_divider`

## Requirements
- R1: While reset is low, out_pulse and ratio_err are 0. After reset the divider runs at the RESET_RATIO value, whose default is 64.
- R2: With a steady legal N, consecutive rising edges of out_pulse are exactly N input clocks apart.
- R3: out_pulse is high for exactly one input clock per period.
- R4: The swallow count A is ratio_in[3:0] and the program count B is ratio_in[16:4]. The period is 16·B + A, and with A = 0 the prescaler divides by 16 for the whole period.
- R5: A change of ratio_in lets the running period finish with the old N. The period that begins at the next output pulse uses the new N.
- R6: ratio_err is 1 one clock after ratio_in is illegal, and 0 one clock after it is legal. A value is illegal when N < 64 or when B < A.
- R7: An illegal ratio_in is ignored. The output period stays at the last legal N.
- R8: The extreme legal settings work: N = 64, N = 255 (A = B = 15) and N = 131071.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | High-rate input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_in | input | 17 | Requested divide ratio N: bits 3:0 are A, bits 16:4 are B |
| out_pulse | output | 1 | One-clock pulse, once every N input clocks |
| ratio_err | output | 1 | High while the presented ratio is illegal |

## Verification
The hardest case to reach is a ratio change that falls inside a running period. The bench has to show that the old period finishes untouched and that the new count starts exactly at the next pulse. To do this, each task aligns to a pulse, changes ratio_in on the clock after that pulse, and then measures two gaps: the first must equal the old N and the second the new N. The same alignment is used to present illegal words in the middle of a period. The bench checks that ratio_err rises one clock later and that the period length stays the same. The full-scale ratio of 131071 is run last, so that its long period is measured only once.

// File: rtl/psw_pkg.sv
// Package: types shared by the pulse-swallow divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package psw_pkg;

    // Modulus the prescaler uses for its next cycle.
    typedef enum logic {
        PRE_DIV16 = 1'b0,
        PRE_DIV17 = 1'b1
    } pre_mode_t;

endpackage

// File: rtl/psw_prescaler.sv
// Dual-modulus prescaler: divides by 2**A_W or 2**A_W + 1.
// Assumes: the mode input is valid in the cycle tc is high; that mode is
// the modulus used for the prescaler cycle that starts next.
module psw_prescaler
    import psw_pkg::*;
#(
    parameter int A_W      = 4,
    parameter bit RST_HIGH = 1'b0
) (
    input  logic      clk_in,
    input  logic      rst_n,
    input  pre_mode_t mode_next,
    output logic      tc
);
    localparam int PC_W = $clog2((2 ** A_W) + 1);
    localparam logic [PC_W-1:0] LOAD_HI = PC_W'(2 ** A_W);
    localparam logic [PC_W-1:0] LOAD_LO = PC_W'((2 ** A_W) - 1);

    logic [PC_W-1:0] pre_cnt;

    assign tc = (pre_cnt == '0);

    // Count down; on terminal count, reload for the requested modulus.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            pre_cnt <= RST_HIGH ? LOAD_HI : LOAD_LO;
        end else if (tc) begin
            pre_cnt <= (mode_next == PRE_DIV17) ? LOAD_HI : LOAD_LO;
        end else begin
            pre_cnt <= pre_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/psw_swallow_ctr.sv
// Swallow counter: counts the prescaler cycles that run at the high modulus.
// Assumes: tc comes from the prescaler, and on a boundary new_a is the
// setting of the period that starts next.
module psw_swallow_ctr
    import psw_pkg::*;
#(
    parameter int          A_W   = 4,
    parameter logic [A_W-1:0] RST_A = '0
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           tc,
    input  logic           boundary,
    input  logic [A_W-1:0] new_a,
    output pre_mode_t      mode_next
);
    logic [A_W-1:0] a_cnt;

    // Next prescaler cycle is high-modulus while high-modulus cycles remain.
    always_comb begin
        if (boundary) begin
            mode_next = (new_a != '0) ? PRE_DIV17 : PRE_DIV16;
        end else begin
            mode_next = (a_cnt > A_W'(1)) ? PRE_DIV17 : PRE_DIV16;
        end
    end

    // Reload at period start; otherwise step down once per prescaler cycle.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            a_cnt <= RST_A;
        end else if (tc) begin
            if (boundary) begin
                a_cnt <= new_a;
            end else if (a_cnt != '0) begin
                a_cnt <= a_cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/psw_program_ctr.sv
// Program counter: counts all prescaler cycles and flags the end of a period.
// Assumes: new_b is at least 1 (a legal setting has B >= 4).
module psw_program_ctr #(
    parameter int             B_W   = 13,
    parameter logic [B_W-1:0] RST_B = B_W'(4)
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           tc,
    input  logic [B_W-1:0] new_b,
    output logic           boundary
);
    logic [B_W-1:0] b_cnt;

    assign boundary = tc && (b_cnt == B_W'(1));

    // Reload on the last prescaler cycle; otherwise step down per cycle.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            b_cnt <= RST_B;
        end else if (tc) begin
            if (boundary) begin
                b_cnt <= new_b;
            end else begin
                b_cnt <= b_cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/psw_ratio_check.sv
// Ratio check and setting hold: splits N into fields, checks that it is legal,
// holds the active setting and flags illegal requests.
// Assumes: the setting changes only on a boundary cycle.
module psw_ratio_check #(
    parameter int             A_W   = 4,
    parameter int             B_W   = 13,
    parameter int             MIN_B = 4,
    parameter logic [A_W-1:0] RST_A = '0,
    parameter logic [B_W-1:0] RST_B = B_W'(4)
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [A_W+B_W-1:0] ratio_in,
    input  logic               boundary,
    output logic [A_W-1:0]     a_set,
    output logic [B_W-1:0]     b_set,
    output logic [A_W-1:0]     new_a,
    output logic [B_W-1:0]     new_b,
    output logic               ratio_err
);
    logic [A_W-1:0] a_in;
    logic [B_W-1:0] b_in;
    logic           in_ok;

    assign a_in  = ratio_in[A_W-1:0];
    assign b_in  = ratio_in[A_W+B_W-1:A_W];
    assign in_ok = (b_in >= B_W'(MIN_B)) && (b_in >= {{(B_W-A_W){1'b0}}, a_in});

    // Setting offered to the counters at a boundary: the request if legal.
    always_comb begin
        new_a = in_ok ? a_in : a_set;
        new_b = in_ok ? b_in : b_set;
    end

    // Capture the setting of each new period.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            a_set <= RST_A;
            b_set <= RST_B;
        end else if (boundary) begin
            a_set <= new_a;
            b_set <= new_b;
        end
    end

    // Register the legality flag every clock.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            ratio_err <= 1'b0;
        end else begin
            ratio_err <= !in_ok;
        end
    end

endmodule

// File: rtl/psw_fb_divider.sv
// Top: pulse-swallow feedback divider. It emits a one-clock pulse every N input
// clocks, with N = 16*B + A taken from ratio_in.
// Assumes: RESET_RATIO is a legal ratio.
module psw_fb_divider
    import psw_pkg::*;
#(
    parameter int A_W         = 4,
    parameter int B_W         = 13,
    parameter int MIN_B       = 4,
    parameter int RESET_RATIO = 64
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [A_W+B_W-1:0] ratio_in,
    output logic               out_pulse,
    output logic               ratio_err
);
    localparam int N_W = A_W + B_W;
    localparam logic [N_W-1:0] RST_N = N_W'(RESET_RATIO);
    localparam logic [A_W-1:0] RST_A = RST_N[A_W-1:0];
    localparam logic [B_W-1:0] RST_B = RST_N[N_W-1:A_W];

    logic           tc;
    logic           boundary;
    pre_mode_t      mode_next;
    logic [A_W-1:0] a_set;
    logic [B_W-1:0] b_set;
    logic [A_W-1:0] new_a;
    logic [B_W-1:0] new_b;

    psw_ratio_check #(
        .A_W(A_W), .B_W(B_W), .MIN_B(MIN_B), .RST_A(RST_A), .RST_B(RST_B)
    ) u_check (
        .clk_in(clk_in), .rst_n(rst_n), .ratio_in(ratio_in), .boundary(boundary),
        .a_set(a_set), .b_set(b_set), .new_a(new_a), .new_b(new_b),
        .ratio_err(ratio_err)
    );

    psw_prescaler #(.A_W(A_W), .RST_HIGH(RST_A != '0)) u_pre (
        .clk_in(clk_in), .rst_n(rst_n), .mode_next(mode_next), .tc(tc)
    );

    psw_swallow_ctr #(.A_W(A_W), .RST_A(RST_A)) u_swallow (
        .clk_in(clk_in), .rst_n(rst_n), .tc(tc), .boundary(boundary),
        .new_a(new_a), .mode_next(mode_next)
    );

    psw_program_ctr #(.B_W(B_W), .RST_B(RST_B)) u_program (
        .clk_in(clk_in), .rst_n(rst_n), .tc(tc), .new_b(new_b),
        .boundary(boundary)
    );

    // Register the end-of-period flag into the output pulse.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            out_pulse <= 1'b0;
        end else begin
            out_pulse <= boundary;
        end
    end

endmodule

// File: rtl/psw_fb_divider_chk.sv
// Checker for psw_fb_divider: pulse width, period length, error flag and
// hold of the setting.
// Assumes: bound to every instance of psw_fb_divider.
module psw_fb_divider_chk #(
    parameter int A_W   = 4,
    parameter int B_W   = 13,
    parameter int MIN_B = 4
) (
    input logic               clk_in,
    input logic               rst_n,
    input logic [A_W+B_W-1:0] ratio_in,
    input logic               out_pulse,
    input logic               ratio_err,
    input logic               boundary,
    input logic [A_W-1:0]     a_set,
    input logic [B_W-1:0]     b_set
);
    localparam int N_W = A_W + B_W;

    logic           in_ok;
    logic [N_W:0]   gap;
    logic [N_W-1:0] per_n;
    logic           seen;

    assign in_ok = (ratio_in[N_W-1:A_W] >= B_W'(MIN_B)) &&
                   (ratio_in[N_W-1:A_W] >= {{(B_W-A_W){1'b0}}, ratio_in[A_W-1:0]});

    // Track clocks since the last pulse and the ratio that period runs on.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            gap   <= '0;
            per_n <= '0;
            seen  <= 1'b0;
        end else if (out_pulse) begin
            gap   <= (N_W+1)'(1);
            per_n <= {b_set, a_set};
            seen  <= 1'b1;
        end else begin
            gap   <= gap + 1'b1;
        end
    end

    p_period_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
        (out_pulse && seen) |-> (gap == {1'b0, per_n}));

    p_single_pulse_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
        out_pulse |=> !out_pulse);

    p_legal_setting_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
        (b_set >= B_W'(MIN_B)) && (b_set >= {{(B_W-A_W){1'b0}}, a_set}));

    p_hold_between_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
        !boundary |=> $stable({b_set, a_set}));

    p_err_set_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        !in_ok |=> ratio_err);

    p_err_clear_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        in_ok |=> !ratio_err);

    p_ignore_bad_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
        !in_ok |=> $stable({b_set, a_set}));

endmodule

bind psw_fb_divider psw_fb_divider_chk #(.A_W(A_W), .B_W(B_W), .MIN_B(MIN_B)) u_chk (
    .clk_in(clk_in), .rst_n(rst_n), .ratio_in(ratio_in), .out_pulse(out_pulse),
    .ratio_err(ratio_err), .boundary(boundary), .a_set(a_set), .b_set(b_set)
);

// File: tb/tb_psw_fb_divider.sv
// Directed bench for psw_fb_divider: one task per scenario, period measured
// in input clocks between pulses.
module tb_psw_fb_divider;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic [16:0] ratio_in = 17'd64;
    logic        out_pulse;
    logic        ratio_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    psw_fb_divider dut (
        .clk_in(clk_in), .rst_n(rst_n), .ratio_in(ratio_in),
        .out_pulse(out_pulse), .ratio_err(ratio_err)
    );

    always #10 clk_in = ~clk_in;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until the next pulse is seen.
    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk_in);
            n++;
        end while (!out_pulse && n < 140000);
    endtask

    // Align to a pulse, present a new ratio, check old then new period.
    task automatic change_to(input string req, input int old_n, input int new_n);
        int g;
        gap(g);
        ratio_in = 17'(new_n);
        gap(g);
        check({req, " old period completes"}, g, old_n);
        gap(g);
        check({req, " new period"}, g, new_n);
    endtask

    task automatic t_reset;
        int g;
        @(negedge clk_in);
        check("R1 pulse low in reset", int'(out_pulse), 0);
        check("R1 err low in reset", int'(ratio_err), 0);
        rst_n = 1'b1;
        gap(g);
        gap(g);
        check("R1 reset ratio period", g, 64);
    endtask

    task automatic t_steady;
        int g;
        change_to("R2 N=100", 64, 100);
        gap(g);
        check("R2 repeated period 100", g, 100);
        @(negedge clk_in);
        check("R3 pulse one clock wide", int'(out_pulse), 0);
        change_to("R2 N=1000", 100, 1000);
        change_to("R2 N=4111", 1000, 4111);
    endtask

    task automatic t_fields;
        change_to("R4 A=0 B=16", 4111, 256);
        change_to("R4 A=7 B=20", 256, 327);
    endtask

    task automatic t_midchange;
        change_to("R5 change 327 to 200", 327, 200);
    endtask

    task automatic t_illegal;
        int g;
        gap(g);
        ratio_in = 17'd63;
        @(negedge clk_in);
        check("R6 err for N<64", int'(ratio_err), 1);
        gap(g);
        gap(g);
        check("R7 period kept at 200 (N=63)", g, 200);
        ratio_in = 17'd90;
        @(negedge clk_in);
        check("R6 err for B<A", int'(ratio_err), 1);
        gap(g);
        gap(g);
        check("R7 period kept at 200 (N=90)", g, 200);
        ratio_in = 17'd200;
        @(negedge clk_in);
        check("R6 err clears for legal N", int'(ratio_err), 0);
    endtask

    task automatic t_extremes;
        change_to("R8 N=64", 200, 64);
        change_to("R8 N=255", 64, 255);
        check("R8 err low at N=255", int'(ratio_err), 0);
        change_to("R8 N=131071", 255, 131071);
    endtask

    initial begin
        repeat (3) @(negedge clk_in);
        t_reset();
        t_steady();
        t_fields();
        t_midchange();
        t_illegal();
        t_extremes();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk_in);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule